// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-line general-purpose I/O port on a byte-wide register bus. Each line has its own direction bit: set, the line drives its output value onto the pad; clear, the line is an input. The port's output-enable and output-value vectors go straight to the pads. Each pad input is sampled through a two-stage synchroniser. The synchronised vector is also exported, so a separate interrupt block can use it.

The data register is reached through a window of addresses rather than a single offset. Address bits [9:2] form a per-line access mask. A write therefore changes exactly the lines named in its address, with no read-modify-write and no lock in software. A read returns zero in every unmasked position. Four fixed identification bytes are also readable. Read data is registered and appears one cycle after the read request.

Top module: `gpio_mask_port`

## Requirements
- R1: While `rst` is high at a clock edge, all direction bits and all output bits clear after that edge: `pad_oe`, `pad_out` and `rdata` are all zero.
- R2: Offsets below 0x400 form the data window. Address bit (n+2) selects line n, so the mask is `addr[9:2]`.
- R3: A data write updates an output bit only where its address mask bit is set. Every other output bit keeps its value.
- R4: The direction byte sits at offset 0x400. Bit n = 1 makes line n an output. `pad_oe` equals the direction byte, and a read at 0x400 returns it.
- R5: A data write leaves the output bit of a line that is an input at that moment unchanged. A value written after the line becomes an output does reach `pad_out`.
- R6: A data read returns the output bit in masked output positions and the synchronised pad bit in masked input positions. Every unmasked position reads as zero.
- R7: A change on `pad_in` driven between clock edges appears on `sync_in` after exactly two rising edges.
- R8: The identification value 0x00041061 is read one byte per word, least significant byte first: 0xFE0 gives 0x61, 0xFE4 gives 0x10, 0xFE8 gives 0x04 and 0xFEC gives 0x00.
- R9: Reads at any other offset return zero, including offsets with non-zero bits [1:0] above the data window. Writes there change neither the direction nor the output bits.
- R10: `rdata` is registered. It carries the read result in the cycle after the edge that samples `rd_en`, and it is zero after any edge where `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Output values toward the pads |
| pad_oe | output | 8 | Output enables toward the pads (1 = drive) |
| sync_in | output | 8 | Synchronised pad inputs for interrupt logic |

## Verification
Several properties are checked on every cycle by the assertions:
- a data write never touches an unmasked bit or an input line's bit;
- a direction write lands as written;
- unmapped writes leave all state stable;
- masked-off read positions are zero;
- the synchroniser delays by exactly two edges.

Other behaviour is shown only by the bench scenarios:
- that the right value lands in the masked bits;
- how output and input lines mix in a read under each of the 256 masks;
- the identification bytes;
- rewriting a value after a line turns to output.

The bench sweeps every mask for writes and reads, and every direction pattern against an all-lines write.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int unsigned DEF_PINS   = 8;
  localparam int unsigned DEF_ADDR_W = 12;
  localparam int unsigned BUS_W      = 8;
  localparam logic [31:0] PORT_ID    = 32'h0004_1061;
  localparam logic [11:0] ID_BASE    = 12'hFE0;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;
  logic [WIDTH-1:0] stage;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta[i]  <= 1'b0;
        stage[i] <= 1'b0;
      end else begin
        meta[i]  <= d[i];
        stage[i] <= meta[i];
      end
    end
  end

  assign q = stage;

  // cycles since reset, saturating, so the two-deep check never looks before reset
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  p_two_stage_r7: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] out_q
);
  localparam int unsigned WIN_BITS = NUM_PINS + 2;
  localparam logic [ADDR_W-1:0] DIR_OFF = ADDR_W'(1) << WIN_BITS;

  logic                in_window;
  logic                dir_hit;
  logic [NUM_PINS-1:0] mask;
  logic [NUM_PINS-1:0] upd;

  assign in_window = (addr >> WIN_BITS) == '0;
  assign dir_hit   = (addr == DIR_OFF);
  assign mask      = addr[WIN_BITS-1:2];
  assign upd       = mask & dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
    end else if (wr_en && dir_hit) begin
      dir_q <= wdata;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) out_q[i] <= 1'b0;
      else if (wr_en && in_window && upd[i]) out_q[i] <= wdata[i];
    end
  end

  p_unmasked_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_window) |=> (((out_q ^ $past(out_q)) & ~$past(mask)) == '0));

  p_input_line_hold_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((out_q ^ $past(out_q)) & ~$past(dir_q)) == '0));

  p_dir_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && dir_hit) |=> (dir_q == $past(wdata)));

  p_unmapped_write_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !in_window && !dir_hit) |=> ($stable(dir_q) && $stable(out_q)));
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_mask_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] dir_q,
  input  logic [NUM_PINS-1:0] out_q,
  input  logic [NUM_PINS-1:0] sync_q,
  output logic [BUS_W-1:0]    rdata
);
  localparam int unsigned WIN_BITS = NUM_PINS + 2;
  localparam logic [ADDR_W-1:0] DIR_OFF = ADDR_W'(1) << WIN_BITS;
  localparam logic [ADDR_W-1:0] ID_OFF  = ADDR_W'(ID_BASE);

  logic                in_window;
  logic                id_hit;
  logic [NUM_PINS-1:0] mask;
  logic [NUM_PINS-1:0] line_val;
  logic [BUS_W-1:0]    rd_val;

  assign in_window = (addr >> WIN_BITS) == '0;
  assign mask      = addr[WIN_BITS-1:2];
  assign id_hit    = ((addr >> 4) == (ID_OFF >> 4)) && (addr[1:0] == 2'b00);
  assign line_val  = (dir_q & out_q) | (~dir_q & sync_q);

  always_comb begin
    rd_val = '0;
    if (in_window)           rd_val = BUS_W'(line_val & mask);
    else if (addr == DIR_OFF) rd_val = BUS_W'(dir_q);
    else if (id_hit)         rd_val = PORT_ID[8*addr[3:2] +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_en ? rd_val : '0;
  end

  p_unmasked_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && in_window) |=> ((rdata & ~BUS_W'($past(mask))) == '0));

  p_unmapped_read_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !in_window && addr != DIR_OFF && !id_hit) |=> (rdata == '0));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned NUM_PINS = DEF_PINS,
  parameter int unsigned ADDR_W   = DEF_ADDR_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BUS_W-1:0]    wdata,
  output logic [BUS_W-1:0]    rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] sync_in
);
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] out_q;

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(sync_in)
  );

  gpio_port_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata[NUM_PINS-1:0]), .dir_q(dir_q), .out_q(out_q)
  );

  gpio_read_mux #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .dir_q(dir_q), .out_q(out_q), .sync_q(sync_in), .rdata(rdata)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && rdata == '0));
endmodule

// File: tb/gpio_mask_port_test.sv
module gpio_mask_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;
  logic [7:0]  sync_in;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_mask_port uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .sync_in(sync_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk); #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    logic [7:0] exp_out;
    logic [7:0] exp_rd;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 out", pad_out, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
    @(negedge clk); rst = 1'b0;

    // R5: write while all lines are inputs is ignored, rewrite after direction change lands
    wr(12'h3FC, 8'hFF);
    chk("R5 input write ignored", pad_out, 8'h00);
    wr(12'h400, 8'hFF);
    chk("R4 oe follows direction", pad_oe, 8'hFF);
    rd(12'h400, r);
    chk("R4 direction readback", r, 8'hFF);
    wr(12'h3FC, 8'hA5);
    chk("R5 rewrite after output", pad_out, 8'hA5);

    // R2/R3: every mask, all lines outputs
    exp_out = 8'hA5;
    for (int m = 0; m < 256; m++) begin
      logic [7:0] d;
      d = 8'(m * 37 + 5);
      wr(12'(m << 2), d);
      exp_out = (exp_out & ~8'(m)) | (d & 8'(m));
      chk("R3 masked write", pad_out, exp_out);
    end
    chk("R2 window end line7", pad_out[7], exp_out[7]);

    // R5: every direction pattern against an all-lines write of the complement
    for (int dpat = 0; dpat < 256; dpat++) begin
      logic [7:0] d;
      wr(12'h400, 8'(dpat));
      d = ~exp_out;
      wr(12'h3FC, d);
      exp_out = (exp_out & ~8'(dpat)) | (d & 8'(dpat));
      chk("R5 direction gated write", pad_out, exp_out);
    end

    // R7: synchroniser latency
    wr(12'h400, 8'h00);
    @(negedge clk); pad_in = 8'h5A;
    @(posedge clk); #1 chk("R7 one edge", sync_in, 8'h00);
    @(posedge clk); #1 chk("R7 two edges", sync_in, 8'h5A);

    // R6: read every mask with mixed directions
    wr(12'h400, 8'hFF);
    wr(12'h3FC, 8'h3C);
    wr(12'h400, 8'hA5);
    @(negedge clk); pad_in = 8'h96;
    repeat (3) @(posedge clk);
    exp_rd = (8'h3C & 8'hA5) | (8'h96 & ~8'hA5);
    for (int m = 0; m < 256; m++) begin
      rd(12'(m << 2), r);
      chk("R6 masked read", r, exp_rd & 8'(m));
    end

    // R8: identification bytes
    rd(12'hFE0, r); chk("R8 id byte0", r, 8'h61);
    rd(12'hFE4, r); chk("R8 id byte1", r, 8'h10);
    rd(12'hFE8, r); chk("R8 id byte2", r, 8'h04);
    rd(12'hFEC, r); chk("R8 id byte3", r, 8'h00);

    // R9: unmapped offsets
    rd(12'hFE1, r); chk("R9 unaligned id", r, 8'h00);
    rd(12'h404, r); chk("R9 read 0x404", r, 8'h00);
    rd(12'h800, r); chk("R9 read 0x800", r, 8'h00);
    wr(12'h404, 8'hFF);
    wr(12'h800, 8'h00);
    wr(12'hFE0, 8'h00);
    chk("R9 dir untouched", pad_oe, 8'hA5);
    chk("R9 out untouched", pad_out, 8'h3C);
    rd(12'h400, r); chk("R9 dir readback", r, 8'hA5);

    // R10: rdata returns to zero once rd_en drops
    @(posedge clk); #1 chk("R10 idle zero", rdata, 8'h00);

    finish_run();
  end
endmodule